// File: doc/BRIEF.md
# Debounced Edge Interrupt Source

This block turns one asynchronous pin, typically a mechanical pushbutton, into a clean interrupt request. The pin first passes through a two-flop synchroniser. A two-bit select input chooses which transitions count: rising only, falling only, both, or none.

The first qualifying transition is accepted at once. It sets a sticky pending flag and starts a lockout timer. The lockout length is an input, given in clock cycles; 20 ms at the block clock is the usual choice. While the timer runs, every further transition is discarded, so a bouncing contact produces exactly one event per press.

Software services the event later. It drops the flag with a one-cycle clear strobe. The block does no other work on the event.

Top module: `edge_irq_lockout`

## Requirements
- R1: The raw pin is synchronised by two flops. The pin is driven between clock edges. An accepted transition sets `irq_pending` at the third rising clock edge after the pin changes, and not earlier.
- R2: With `edge_sel` = 2'b01, only low-to-high transitions of the pin are accepted.
- R3: With `edge_sel` = 2'b10, only high-to-low transitions of the pin are accepted.
- R4: With `edge_sel` = 2'b11, transitions in either direction are accepted.
- R5: With `edge_sel` = 2'b00, no transition is accepted and `irq_pending` never rises.
- R6: Suppose a transition is accepted, and it is sampled at rising edge n. Any qualifying transition sampled at edges n+1 through n+L is ignored, where L = `lockout_cycles`. The first qualifying transition sampled at edge n+L+1 or later is accepted.
- R7: An ignored transition does not restart or extend the lockout window.
- R8: With `lockout_cycles` = 0, every qualifying transition is accepted.
- R9: `irq_pending` stays set until a cycle in which `irq_clr` is high. It then clears at that clock edge.
- R10: If `irq_clr` is high in the same cycle that an accepted transition reaches the flag, `irq_pending` stays set.
- R11: Synchronous reset clears `irq_pending` and the lockout timer. Reset also loads the current pin level into the synchroniser. A pin held high through reset therefore produces no event after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous pin level |
| edge_sel | input | 2 | 00 off, 01 rising, 10 falling, 11 both |
| lockout_cycles | input | LOCK_W | Ignore window after an accepted transition, in clock cycles |
| irq_clr | input | 1 | One-cycle clear of the pending flag |
| irq_pending | output | 1 | Registered sticky interrupt request |

## Verification
The properties assume two things: `edge_sel` and `lockout_cycles` are steady while the source is armed, and the pin does not change on the cycle that reset is released. The stimulus follows both rules. Both settings change only while reset is held, and the pin is only moved at falling clock edges, away from the end of a reset. Within those bounds the bench compares the flag every cycle against an arithmetic record of accepted sample indices. The stimulus sweeps every select value across several lockout lengths, with pseudo-random bounce bursts and clear strobes.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // Reset preloads every stage with the live pin so no edge appears at release.
  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{d}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_qualify.sv
module edge_qualify
  import edge_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       seed,
  input  logic       level,
  input  edge_mode_e mode,
  output logic       hit
);
  logic prev;
  logic went_up;
  logic went_down;

  always_ff @(posedge clk) begin
    if (rst) prev <= seed;
    else     prev <= level;
  end

  assign went_up   = level & ~prev;
  assign went_down = ~level & prev;

  always_comb begin
    case (mode)
      EDGE_RISE: hit = went_up;
      EDGE_FALL: hit = went_down;
      EDGE_ANY:  hit = went_up | went_down;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lockout_timer.sv
module lockout_timer #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] length,
  output logic         busy
);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)              remain <= '0;
    else if (start)       remain <= length;
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/pend_flag.sv
module pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  // Set wins over clear so an event arriving with the clear is not lost.
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/edge_irq_lockout.sv
module edge_irq_lockout
  import edge_irq_pkg::*;
#(
  parameter int LOCK_W      = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_raw,
  input  logic [1:0]        edge_sel,
  input  logic [LOCK_W-1:0] lockout_cycles,
  input  logic              irq_clr,
  output logic              irq_pending
);
  logic sync_level;
  logic edge_hit;
  logic lock_busy;
  logic accept;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (sync_level)
  );

  edge_qualify u_qual (
    .clk   (clk),
    .rst   (rst),
    .seed  (pin_raw),
    .level (sync_level),
    .mode  (edge_mode_e'(edge_sel)),
    .hit   (edge_hit)
  );

  assign accept = edge_hit & ~lock_busy;

  lockout_timer #(.W(LOCK_W)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .length (lockout_cycles),
    .busy   (lock_busy)
  );

  pend_flag u_flag (
    .clk (clk),
    .rst (rst),
    .set (accept),
    .clr (irq_clr),
    .q   (irq_pending)
  );
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int LOCK_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        edge_sel,
  input logic [LOCK_W-1:0] lockout_cycles,
  input logic              irq_clr,
  input logic              irq_pending,
  input logic              accept,
  input logic              sync_level,
  input logic              lock_busy
);
  // R1
  rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pending) |-> $past(accept));

  // R2
  rise_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && edge_sel == 2'b01) |-> sync_level);

  // R3
  fall_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && edge_sel == 2'b10) |-> !sync_level);

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == 2'b00 && !irq_pending) |=> !irq_pending);

  // R6
  lock_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && lockout_cycles != '0) |=> lock_busy);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && !irq_clr) |=> irq_pending);

  // R10
  clr_race_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && irq_clr) |=> irq_pending);

  // R11
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_pending && !lock_busy));
endmodule

bind edge_irq_lockout edge_irq_chk #(.LOCK_W(LOCK_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .edge_sel       (edge_sel),
  .lockout_cycles (lockout_cycles),
  .irq_clr        (irq_clr),
  .irq_pending    (irq_pending),
  .accept         (accept),
  .sync_level     (sync_level),
  .lock_busy      (lock_busy)
);

// File: tb/tb_edge_irq_lockout.sv
module tb_edge_irq_lockout;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_W     = 21;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pin_raw = 1'b0;
  logic [1:0]        edge_sel = 2'b11;
  logic [LOCK_W-1:0] lockout_cycles = '0;
  logic              irq_clr = 1'b0;
  logic              irq_pending;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit chk_en = 0;

  edge_irq_lockout #(.LOCK_W(LOCK_W)) dut (
    .clk            (clk),
    .rst            (rst),
    .pin_raw        (pin_raw),
    .edge_sel       (edge_sel),
    .lockout_cycles (lockout_cycles),
    .irq_clr        (irq_clr),
    .irq_pending    (irq_pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: index of each rising edge; acceptance from sample spacing.
  logic       m_last;
  logic [1:0] m_pipe;
  logic       m_pend;
  bit         m_have;
  int         m_n;
  int         m_acc;

  always @(posedge clk) begin
    if (rst) begin
      m_last <= pin_raw;
      m_pipe <= 2'b00;
      m_pend <= 1'b0;
      m_have <= 1'b0;
      m_n    <= 0;
      m_acc  <= 0;
    end else begin : model_step
      logic moved;
      logic qual;
      logic ok;
      moved = (pin_raw != m_last);
      qual  = moved && (edge_sel == 2'b11 ||
                        (edge_sel == 2'b01 && pin_raw) ||
                        (edge_sel == 2'b10 && !pin_raw));
      ok    = qual && (!m_have || (m_n - m_acc) > int'(lockout_cycles));
      if (ok) begin
        m_have <= 1'b1;
        m_acc  <= m_n;
      end
      m_n    <= m_n + 1;
      m_pipe <= {m_pipe[0], ok};
      m_pend <= m_pipe[1] ? 1'b1 : (irq_clr ? 1'b0 : m_pend);
      m_last <= pin_raw;
    end
  end

  function automatic string cfg_tag();
    string s;
    case (edge_sel)
      2'b00:   s = "R5";
      2'b01:   s = "R2";
      2'b10:   s = "R3";
      default: s = "R4";
    endcase
    if (lockout_cycles == 0) s = {s, "/R8"};
    else                     s = {s, "/R6"};
    return s;
  endfunction

  always @(negedge clk) begin
    if (chk_en && !rst && !finished) begin
      checks++;
      if (irq_pending !== m_pend) begin
        errors++;
        $display("FAIL %s/R9 cycle-model sel=%b L=%0d: actual %b expected %b",
                 cfg_tag(), edge_sel, lockout_cycles, irq_pending, m_pend);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] sel, input int len, input logic lvl);
    rst = 1'b1;
    edge_sel = sel;
    lockout_cycles = LOCK_W'(len);
    pin_raw = lvl;
    irq_clr = 1'b0;
    tick(); tick(); tick();
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset(2'b01, 0, 1'b0);
    chk_en = 1;
    check("R11 reset state", irq_pending, 1'b0);

    // R1: latency of the synchroniser and flag
    pin_raw = 1'b1;
    tick(); check("R1 after edge 1", irq_pending, 1'b0);
    tick(); check("R1 after edge 2", irq_pending, 1'b0);
    tick(); check("R1 after edge 3", irq_pending, 1'b1);
    // R9: sticky until clear
    tick(); tick(); check("R9 held", irq_pending, 1'b1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R9 cleared", irq_pending, 1'b0);

    // R11: pin high through reset gives no event
    do_reset(2'b01, 0, 1'b1);
    repeat (5) tick();
    check("R11 no false edge", irq_pending, 1'b0);

    // R11: reset ends a running lockout
    do_reset(2'b11, 1000, 1'b0);
    pin_raw = 1'b1; repeat (4) tick();
    check("R11 first event", irq_pending, 1'b1);
    do_reset(2'b11, 1000, 1'b1);
    pin_raw = 1'b0; repeat (3) tick();
    check("R11 lockout cleared", irq_pending, 1'b1);

    // R10: clear coincides with the set
    do_reset(2'b11, 0, 1'b0);
    pin_raw = 1'b1; tick(); tick();
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R10 set beats clear", irq_pending, 1'b1);

    // R7: ignored edges do not stretch the window (L=6)
    do_reset(2'b11, 6, 1'b0);
    pin_raw = 1'b1; tick(); tick(); tick();
    check("R7 first accept", irq_pending, 1'b1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;   // pin sampled n .. now n+3
    pin_raw = 1'b0; tick();                   // sampled n+4, ignored
    pin_raw = 1'b1; tick();                   // sampled n+5, ignored
    tick();
    pin_raw = 1'b0; tick();                   // sampled n+7, accepted
    tick(); tick();
    check("R7 accept at L+1", irq_pending, 1'b1);
    tick();
    check("R6 no extra event", irq_pending, 1'b1);

    // Sweep of all select values, several lockout lengths, bounce bursts
    lfsr = 16'hACE1;
    for (int sel = 0; sel < 4; sel++) begin
      for (int li = 0; li < 6; li++) begin
        int len;
        case (li)
          0: len = 0;
          1: len = 1;
          2: len = 2;
          3: len = 3;
          4: len = 4;
          default: len = 7;
        endcase
        do_reset(2'(sel), len, lfsr[2]);
        for (int k = 0; k < 160; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          if (k % 40 < 25) begin
            if (lfsr[0]) pin_raw = ~pin_raw;
          end
          irq_clr = (lfsr[5:3] == 3'b000);
          tick();
        end
        irq_clr = 1'b0;
        pin_raw = 1'b1;
        repeat (len + 4) tick();
      end
    end

    chk_en = 0;
    finish_run();
  end
endmodule